// File: doc/BRIEF.md
# UART Interrupt Enable and Prioritizer

This block is the interrupt controller of one UART channel. It keeps a small writable enable register and one pending flag per interrupt source. The sources are receiver line error, received character, receive character timeout, transmit holding register empty and modem-status change. Each cycle it picks the highest-priority source that is both pending and enabled. It drives one active-high interrupt line and a 4-bit identification code that the CPU reads to find out which source to service.

The serial shifters, the baud logic and the FIFOs are outside this block. Their status arrives as single-cycle event pulses. The CPU register accesses that service a source arrive as single-cycle strobes: receive buffer read, transmit holding write, line-status read, modem-status read and identification read. Each strobe clears the source it belongs to.

The controller is a registered state machine. The state names the source that is currently reported. The states are ST_NONE, ST_LINE, ST_RXDATA, ST_RXTMO, ST_TXEMPTY and ST_MODEM. On every clock edge the state moves to the winner of the arbitration. The arbitration runs over the pending flags and enable bits as they will be after that edge. Any state can therefore move to any other in one transition. The transitions are: raise (ST_NONE to a source state), preempt (to a higher-priority source), service (to a lower-priority source or to ST_NONE once the reported source clears) and mask (to ST_NONE when the enables are removed). The interrupt line is high in every state except ST_NONE.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, irq is 0, iid is 4'b0001 and ier_rdata is 8'h00. All pending flags are clear.
- R2: A write with ier_wr stores ier_wdata[3:0]. ier_rdata returns those four bits with bits 7:4 always 0. Bit 0 enables receive data and timeout, bit 1 enables transmit empty, bit 2 enables line status and bit 3 enables modem status.
- R3: While enable bits 3:0 are all 0, irq stays 0 and iid stays 4'b0001, even with sources pending.
- R4: Priority from highest to lowest is line status (iid 4'b0110), then received data (4'b0100) or character timeout (4'b1100), then transmit empty (4'b0010), then modem status (4'b0000). The code 4'b0001 means nothing is reported.
- R5: A received-character event sets the data source. A receive buffer read clears it.
- R6: A timeout event sets the timeout source at the same priority level as received data. Received data is reported first when both are pending. A receive buffer read clears the timeout source too.
- R7: A transmit-empty event sets the transmit source. A transmit holding write clears it.
- R8: An identification read while iid is 4'b0010 clears the transmit source, unless a transmit-empty event arrives in the same cycle. An identification read in any other state clears nothing.
- R9: A line-error event sets the line-status source. A line-status read clears it.
- R10: A modem-change event sets the modem source. A modem-status read clears it.
- R11: Pending flags are kept while their enable is 0. A write that enables a pending source changes irq and iid at the same clock edge that loads the enable.
- R12: An event or strobe sampled at a clock edge shows on irq and iid right after that edge. If a source's event and its clearing access arrive in the same cycle, the event wins.
- R13: irq is 1 exactly when iid differs from 4'b0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ier_wr | input | 1 | Write strobe for the enable register |
| ier_wdata | input | REG_W | Write data for the enable register |
| ier_rdata | output | REG_W | Enable register read-back, upper bits zero |
| iir_rd | input | 1 | Identification register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| lsr_rd | input | 1 | Line-status register read strobe |
| msr_rd | input | 1 | Modem-status register read strobe |
| ls_evt | input | 1 | Receiver line error detected |
| rx_data_evt | input | 1 | Character placed in receive buffer |
| rx_tmo_evt | input | 1 | Receive character timeout |
| thr_empty_evt | input | 1 | Transmit holding register became empty |
| ms_evt | input | 1 | Modem-status input changed |
| irq | output | 1 | Interrupt request, active high, registered |
| iid | output | 4 | Identification code of the reported source |

## Verification
The bench builds the block with the default REG_W of 8. That width shows the unused upper half of the enable register, so writes of 8'hFF and 8'hF0 prove that bits 7:4 never read back. Because every source has one enable bit inside the low nibble, a single table can walk all five sources through raise, preempt, service and mask. It can also line up simultaneous event and clear strobes on the same edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC = 5;
    localparam int ID_W    = 4;

    // pending-vector positions
    localparam int SRC_LINE = 0;
    localparam int SRC_RXD  = 1;
    localparam int SRC_TMO  = 2;
    localparam int SRC_TX   = 3;
    localparam int SRC_MDM  = 4;

    // enable-register bit positions
    localparam int EN_RX   = 0;
    localparam int EN_TX   = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MDM  = 3;
    localparam int EN_W    = 4;

    localparam logic [ID_W-1:0] ID_NONE  = 4'b0001;
    localparam logic [ID_W-1:0] ID_LINE  = 4'b0110;
    localparam logic [ID_W-1:0] ID_RXD   = 4'b0100;
    localparam logic [ID_W-1:0] ID_TMO   = 4'b1100;
    localparam logic [ID_W-1:0] ID_TX    = 4'b0010;
    localparam logic [ID_W-1:0] ID_MDM   = 4'b0000;

    typedef enum logic [2:0] {
        ST_NONE    = 3'd0,
        ST_LINE    = 3'd1,
        ST_RXDATA  = 3'd2,
        ST_RXTMO   = 3'd3,
        ST_TXEMPTY = 3'd4,
        ST_MODEM   = 3'd5
    } irq_state_e;

endpackage

// File: rtl/uart_irq_ier.sv
module uart_irq_ier #(
    parameter int REG_W = 8,
    parameter int EN_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    output logic [EN_W-1:0]  en_next,
    output logic [REG_W-1:0] rdata
);
    logic [EN_W-1:0] en_q;
    logic            unused_hi;

    assign unused_hi = ^wdata[REG_W-1:EN_W];
    assign en_next   = wr ? wdata[EN_W-1:0] : en_q;
    assign rdata     = {{(REG_W-EN_W){1'b0}}, en_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_next;
    end
endmodule

// File: rtl/uart_irq_pend.sv
module uart_irq_pend #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend_next
);
    logic [N-1:0] pend_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        // an event in the same cycle as its clear wins
        assign pend_next[i] = set[i] | (pend_q[i] & ~clr[i]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q[i] <= 1'b0;
            else        pend_q[i] <= pend_next[i];
        end
    end
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
    import uart_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend,
    input  logic [EN_W-1:0]    en,
    output irq_state_e         winner
);
    always_comb begin
        if (pend[SRC_LINE] && en[EN_LINE])     winner = ST_LINE;
        else if (pend[SRC_RXD] && en[EN_RX])   winner = ST_RXDATA;
        else if (pend[SRC_TMO] && en[EN_RX])   winner = ST_RXTMO;
        else if (pend[SRC_TX] && en[EN_TX])    winner = ST_TXEMPTY;
        else if (pend[SRC_MDM] && en[EN_MDM])  winner = ST_MODEM;
        else                                   winner = ST_NONE;
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ier_wr,
    input  logic [REG_W-1:0] ier_wdata,
    output logic [REG_W-1:0] ier_rdata,
    input  logic             iir_rd,
    input  logic             rbr_rd,
    input  logic             thr_wr,
    input  logic             lsr_rd,
    input  logic             msr_rd,
    input  logic             ls_evt,
    input  logic             rx_data_evt,
    input  logic             rx_tmo_evt,
    input  logic             thr_empty_evt,
    input  logic             ms_evt,
    output logic             irq,
    output logic [ID_W-1:0]  iid
);
    irq_state_e         state_q;
    irq_state_e         state_d;
    logic [EN_W-1:0]    en_next;
    logic [NUM_SRC-1:0] src_set;
    logic [NUM_SRC-1:0] src_clr;
    logic [NUM_SRC-1:0] pend_next;

    uart_irq_ier #(.REG_W(REG_W), .EN_W(EN_W)) u_ier (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ier_wr),
        .wdata   (ier_wdata),
        .en_next (en_next),
        .rdata   (ier_rdata)
    );

    always_comb begin
        src_set           = '0;
        src_set[SRC_LINE] = ls_evt;
        src_set[SRC_RXD]  = rx_data_evt;
        src_set[SRC_TMO]  = rx_tmo_evt;
        src_set[SRC_TX]   = thr_empty_evt;
        src_set[SRC_MDM]  = ms_evt;

        src_clr           = '0;
        src_clr[SRC_LINE] = lsr_rd;
        src_clr[SRC_RXD]  = rbr_rd;
        src_clr[SRC_TMO]  = rbr_rd;
        src_clr[SRC_TX]   = thr_wr | (iir_rd && (state_q == ST_TXEMPTY));
        src_clr[SRC_MDM]  = msr_rd;
    end

    uart_irq_pend #(.N(NUM_SRC)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .set       (src_set),
        .clr       (src_clr),
        .pend_next (pend_next)
    );

    uart_irq_arb u_arb (
        .pend   (pend_next),
        .en     (en_next),
        .winner (state_d)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NONE;
        else        state_q <= state_d;
    end

    // outputs decoded from the registered state
    always_comb begin
        irq = 1'b1;
        unique case (state_q)
            ST_NONE:    begin iid = ID_NONE; irq = 1'b0; end
            ST_LINE:    iid = ID_LINE;
            ST_RXDATA:  iid = ID_RXD;
            ST_RXTMO:   iid = ID_TMO;
            ST_TXEMPTY: iid = ID_TX;
            ST_MODEM:   iid = ID_MDM;
            default:    begin iid = ID_NONE; irq = 1'b0; end
        endcase
    end
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ier_wr,
    input logic [REG_W-1:0] ier_rdata,
    input logic             rbr_rd,
    input logic             thr_wr,
    input logic             lsr_rd,
    input logic             msr_rd,
    input logic             ls_evt,
    input logic             rx_data_evt,
    input logic             rx_tmo_evt,
    input logic             thr_empty_evt,
    input logic             ms_evt,
    input logic             irq,
    input logic [3:0]       iid
);
    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rdata[3:0] == 4'h0) |-> (!irq && iid == 4'b0001));

    // R9
    line_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_evt && ier_rdata[2] && !ier_wr) |=> (iid == 4'b0110));

    // R9
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !ls_evt) |=> (iid != 4'b0110));

    // R5
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rbr_rd && !rx_data_evt && !rx_tmo_evt) |=>
            (iid != 4'b0100 && iid != 4'b1100));

    // R7
    tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_wr && !thr_empty_evt) |=> (iid != 4'b0010));

    // R10
    mdm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !ms_evt) |=> (iid != 4'b0000));

    // R13
    irq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (iid != 4'b0001));
endmodule

bind uart_irq_ctrl uart_irq_chk #(.REG_W(REG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ier_wr        (ier_wr),
    .ier_rdata     (ier_rdata),
    .rbr_rd        (rbr_rd),
    .thr_wr        (thr_wr),
    .lsr_rd        (lsr_rd),
    .msr_rd        (msr_rd),
    .ls_evt        (ls_evt),
    .rx_data_evt   (rx_data_evt),
    .rx_tmo_evt    (rx_tmo_evt),
    .thr_empty_evt (thr_empty_evt),
    .ms_evt        (ms_evt),
    .irq           (irq),
    .iid           (iid)
);

// File: tb/uart_irq_ctrl_test.sv
module uart_irq_ctrl_test;
    localparam int REG_W = 8;

    // strobes: {iir_rd, rbr_rd, thr_wr, lsr_rd, msr_rd}
    // events:  {ls, rx_data, rx_tmo, thr_empty, ms}
    typedef struct packed {
        logic       wr;
        logic [7:0] wd;
        logic [4:0] stb;
        logic [4:0] evt;
        logic       e_irq;
        logic [3:0] e_iid;
        logic [7:0] e_ier;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 8'hFF, 5'b00000, 5'b00000, 1'b0, 4'b0001, 8'h0F, 8'd2 },  // R2
        '{1'b1, 8'h00, 5'b00000, 5'b11111, 1'b0, 4'b0001, 8'h00, 8'd3 },  // R3
        '{1'b1, 8'h08, 5'b00000, 5'b00000, 1'b1, 4'b0000, 8'h08, 8'd11},  // R11
        '{1'b1, 8'h0A, 5'b00000, 5'b00000, 1'b1, 4'b0010, 8'h0A, 8'd4 },  // R4
        '{1'b1, 8'h0B, 5'b00000, 5'b00000, 1'b1, 4'b0100, 8'h0B, 8'd6 },  // R6
        '{1'b1, 8'h0F, 5'b00000, 5'b00000, 1'b1, 4'b0110, 8'h0F, 8'd4 },  // R4
        '{1'b0, 8'h00, 5'b00010, 5'b00000, 1'b1, 4'b0100, 8'h0F, 8'd9 },  // R9
        '{1'b0, 8'h00, 5'b01000, 5'b00000, 1'b1, 4'b0010, 8'h0F, 8'd5 },  // R5
        '{1'b0, 8'h00, 5'b10000, 5'b00000, 1'b1, 4'b0000, 8'h0F, 8'd8 },  // R8
        '{1'b0, 8'h00, 5'b00001, 5'b00000, 1'b0, 4'b0001, 8'h0F, 8'd10},  // R10
        '{1'b0, 8'h00, 5'b00000, 5'b00100, 1'b1, 4'b1100, 8'h0F, 8'd6 },  // R6
        '{1'b0, 8'h00, 5'b01000, 5'b01000, 1'b1, 4'b0100, 8'h0F, 8'd12},  // R12
        '{1'b0, 8'h00, 5'b01000, 5'b00000, 1'b0, 4'b0001, 8'h0F, 8'd5 },  // R5
        '{1'b0, 8'h00, 5'b00000, 5'b00010, 1'b1, 4'b0010, 8'h0F, 8'd7 },  // R7
        '{1'b0, 8'h00, 5'b00100, 5'b00000, 1'b0, 4'b0001, 8'h0F, 8'd7 },  // R7
        '{1'b0, 8'h00, 5'b00000, 5'b00010, 1'b1, 4'b0010, 8'h0F, 8'd7 },  // R7
        '{1'b0, 8'h00, 5'b10000, 5'b00010, 1'b1, 4'b0010, 8'h0F, 8'd8 },  // R8
        '{1'b0, 8'h00, 5'b10000, 5'b00000, 1'b0, 4'b0001, 8'h0F, 8'd8 },  // R8
        '{1'b0, 8'h00, 5'b00000, 5'b10001, 1'b1, 4'b0110, 8'h0F, 8'd9 },  // R9
        '{1'b0, 8'h00, 5'b00010, 5'b00000, 1'b1, 4'b0000, 8'h0F, 8'd10},  // R10
        '{1'b1, 8'h00, 5'b00000, 5'b00000, 1'b0, 4'b0001, 8'h00, 8'd3 },  // R3
        '{1'b1, 8'h08, 5'b00000, 5'b00000, 1'b1, 4'b0000, 8'h08, 8'd11},  // R11
        '{1'b0, 8'h00, 5'b10000, 5'b00000, 1'b1, 4'b0000, 8'h08, 8'd8 },  // R8
        '{1'b0, 8'h00, 5'b00001, 5'b00001, 1'b1, 4'b0000, 8'h08, 8'd12},  // R12
        '{1'b0, 8'h00, 5'b00001, 5'b00000, 1'b0, 4'b0001, 8'h08, 8'd10},  // R10
        '{1'b1, 8'hF0, 5'b00000, 5'b00000, 1'b0, 4'b0001, 8'h00, 8'd2 }   // R2
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ier_wr = 1'b0;
    logic [REG_W-1:0] ier_wdata = '0;
    logic [REG_W-1:0] ier_rdata;
    logic             iir_rd = 1'b0, rbr_rd = 1'b0, thr_wr = 1'b0, lsr_rd = 1'b0, msr_rd = 1'b0;
    logic             ls_evt = 1'b0, rx_data_evt = 1'b0, rx_tmo_evt = 1'b0;
    logic             thr_empty_evt = 1'b0, ms_evt = 1'b0;
    logic             irq;
    logic [3:0]       iid;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    uart_irq_ctrl #(.REG_W(REG_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_rdata(ier_rdata),
        .iir_rd(iir_rd), .rbr_rd(rbr_rd), .thr_wr(thr_wr),
        .lsr_rd(lsr_rd), .msr_rd(msr_rd),
        .ls_evt(ls_evt), .rx_data_evt(rx_data_evt), .rx_tmo_evt(rx_tmo_evt),
        .thr_empty_evt(thr_empty_evt), .ms_evt(ms_evt),
        .irq(irq), .iid(iid)
    );

    task automatic check(input int req, input logic e_irq, input logic [3:0] e_iid,
                         input logic [7:0] e_ier);
        n_chk++;
        if (irq !== e_irq || iid !== e_iid || ier_rdata !== e_ier) begin
            n_bad++;
            $display("FAIL R%0d: irq=%b iid=%b ier=%h expected irq=%b iid=%b ier=%h",
                     req, irq, iid, ier_rdata, e_irq, e_iid, e_ier);
        end
    endtask

    task automatic drive(input vec_t v);
        ier_wr    = v.wr;
        ier_wdata = v.wd;
        {iir_rd, rbr_rd, thr_wr, lsr_rd, msr_rd} = v.stb;
        {ls_evt, rx_data_evt, rx_tmo_evt, thr_empty_evt, ms_evt} = v.evt;
    endtask

    task automatic idle();
        ier_wr = 1'b0; ier_wdata = '0;
        {iir_rd, rbr_rd, thr_wr, lsr_rd, msr_rd} = '0;
        {ls_evt, rx_data_evt, rx_tmo_evt, thr_empty_evt, ms_evt} = '0;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(1, 1'b0, 4'b0001, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, 1'b0, 4'b0001, 8'h00);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check(int'(VEC[i].req), VEC[i].e_irq, VEC[i].e_iid, VEC[i].e_ier);
        end
        idle();

        // R1: reset in the middle of activity clears enables and pending state
        drive('{1'b1, 8'h0F, 5'b00000, 5'b11111, 1'b0, 4'b0000, 8'h00, 8'd0});
        @(negedge clk);
        check(1, 1'b1, 4'b0110, 8'h0F);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 1'b0, 4'b0001, 8'h00);
        rst_n = 1'b1;
        ier_wr = 1'b1; ier_wdata = 8'h0F;
        @(negedge clk);
        idle();
        // R1: nothing left pending after reset, even with all enabled
        check(1, 1'b0, 4'b0001, 8'h0F);

        // R13: steady state holds without stimulus
        @(negedge clk);
        check(13, 1'b0, 4'b0001, 8'h0F);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule